// File: doc/BRIEF.md
# Four-Times Oversampled Serial Byte Receiver

This block turns an asynchronous serial line into bytes. The frame is fixed: one start bit, eight data bits sent least significant bit first, no parity, and one stop bit. A programmable 16-bit divisor, loaded one byte at a time, sets the period of an internal sample tick to divisor + 1 clock cycles. Each serial bit lasts four ticks, so for a clock `f` and bit rate `b` the divisor is `f / (4*b) - 1`.

The line passes through a two-flop synchroniser and idles high. A start bit must begin with a falling edge. It is accepted only if the line is still low one tick later, which is the middle of the bit. Each data bit and the stop bit are then sampled four ticks apart. Finished bytes enter a four-entry first-word-fall-through queue. A register front end reads the queue from the head and pops it with a one-cycle strobe.

Occupancy flags report empty, full and one-slot-left. Two sticky error flags capture a low stop bit and a byte lost to a full queue. Each error flag is cleared by its own strobe.

Top module: `uart_rx4x`

## Requirements
- R1: The sample tick repeats every divisor + 1 clocks. One bit lasts four ticks. `divWrLo` loads `divWrData` into divisor bits 7:0 and `divWrHi` loads it into bits 15:8. Either write restarts the tick counter, so a frame sent at the new rate right after the write is received correctly (the high byte included).
- R2: An 8N1 frame is assembled least significant bit first. The byte is appended to the queue, and the oldest byte is shown on `rdData` while the queue is not empty.
- R3: A start bit needs a high-to-low transition seen on the tick samples, and the line must still be low on the following tick. A low pulse shorter than one tick period queues nothing, and a normal frame after it is received correctly.
- R4: The flags follow the count of stored bytes: `fifoEmpty` at 0, `fifoOneLeft` only at exactly 3, `fifoFull` at 4. A `popEn` pulse removes the head. A `popEn` pulse while empty changes nothing.
- R5: A byte that completes while the queue holds four entries is discarded and sets `overrunErr`. The four stored bytes stay readable, in order.
- R6: A stop bit sampled low sets `frameErr`. The byte is still queued if there is room.
- R7: Both error flags stay set until their own clear strobe (`clrFrameErr`, `clrOverrunErr`). Clearing touches no queued data, and a new error in the same cycle as a clear wins.
- R8: After reset the queue is empty, both error flags are low, no occupancy flag other than `fifoEmpty` is set, and the divisor holds its reset parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| divWrLo | input | 1 | Load low divisor byte from divWrData |
| divWrHi | input | 1 | Load high divisor byte from divWrData |
| divWrData | input | 8 | Divisor byte value |
| serialIn | input | 1 | Asynchronous serial line, idle high |
| popEn | input | 1 | Remove the head byte of the queue |
| clrFrameErr | input | 1 | Clear the frame error flag |
| clrOverrunErr | input | 1 | Clear the overrun flag |
| rdData | output | 8 | Head byte of the queue |
| fifoEmpty | output | 1 | Queue holds no bytes |
| fifoOneLeft | output | 1 | Queue holds exactly three bytes |
| fifoFull | output | 1 | Queue holds four bytes |
| frameErr | output | 1 | Sticky: a stop bit was sampled low |
| overrunErr | output | 1 | Sticky: a byte was lost to a full queue |

## Verification
The checks assume the following about the inputs:
- The serial line keeps a bit period of four ticks, within the sampling margin, and returns high between frames.
- The divisor is rewritten only while the line is idle.
- The clear and pop strobes are single-cycle pulses.

The stimulus keeps to these assumptions. It derives every bit duration from the divisor it last wrote and changes the divisor only between frames. It inserts a full idle bit after each stop bit and drives all strobes for exactly one cycle at the falling clock edge. Random divisors, byte values and fill depths run against a queue model in the bench. Directed cases cover the overrun, frame-error, glitch, empty-pop and large-divisor corners.

// File: rtl/uart_rx4x_pkg.sv
package uart_rx4x_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_e;

  // strobes from control to datapath, each valid for one clock
  typedef struct packed {
    logic shiftEn;   // capture the current line sample as the next data bit
    logic pushEn;    // frame finished, queue the assembled byte
    logic stopLow;   // stop bit sampled low on this push
  } rxStrobe_t;
endpackage

// File: rtl/uart_rx4x_ctrl.sv
module uart_rx4x_ctrl
  import uart_rx4x_pkg::*;
#(
  parameter int TICKS_PER_BIT = 4,
  parameter int DATA_BITS     = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      rxBit,
  output rxStrobe_t strobe
);
  localparam int PW = $clog2(TICKS_PER_BIT);
  localparam int BW = $clog2(DATA_BITS);
  localparam logic [PW-1:0] LAST_PHASE = PW'(TICKS_PER_BIT - 1);
  localparam logic [PW-1:0] MID_PHASE  = PW'(TICKS_PER_BIT / 2 - 2);
  localparam logic [BW-1:0] LAST_BIT   = BW'(DATA_BITS - 1);

  rxState_e      state;
  logic [PW-1:0] phase;
  logic [BW-1:0] bitIdx;
  logic          lastHigh;
  logic          atBitEdge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= '0;
      bitIdx   <= '0;
      lastHigh <= 1'b1;
    end else if (tick) begin
      lastHigh <= rxBit;
      unique case (state)
        ST_IDLE: begin
          if (!rxBit && lastHigh) begin
            state <= ST_START;
            phase <= '0;
          end
        end
        ST_START: begin
          if (phase == MID_PHASE) begin
            phase  <= '0;
            bitIdx <= '0;
            state  <= rxBit ? ST_IDLE : ST_DATA;
          end else begin
            phase <= phase + PW'(1);
          end
        end
        ST_DATA: begin
          if (phase == LAST_PHASE) begin
            phase <= '0;
            if (bitIdx == LAST_BIT) state <= ST_STOP;
            else bitIdx <= bitIdx + BW'(1);
          end else begin
            phase <= phase + PW'(1);
          end
        end
        ST_STOP: begin
          if (phase == LAST_PHASE) begin
            phase <= '0;
            state <= ST_IDLE;
          end else begin
            phase <= phase + PW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    atBitEdge      = tick && (phase == LAST_PHASE);
    strobe.shiftEn = atBitEdge && (state == ST_DATA);
    strobe.pushEn  = atBitEdge && (state == ST_STOP);
    strobe.stopLow = strobe.pushEn && !rxBit;
  end
endmodule

// File: rtl/uart_rx4x_dp.sv
module uart_rx4x_dp
  import uart_rx4x_pkg::*;
#(
  parameter int          DIV_W     = 16,
  parameter logic [15:0] DIV_INIT  = 16'd3,
  parameter int          DATA_BITS = 8,
  parameter int          DEPTH     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 divWrLo,
  input  logic                 divWrHi,
  input  logic [DIV_W/2-1:0]   divWrData,
  input  logic                 serialIn,
  input  rxStrobe_t            strobe,
  input  logic                 popEn,
  input  logic                 clrFrameErr,
  input  logic                 clrOverrunErr,
  output logic                 tick,
  output logic                 rxBit,
  output logic [DATA_BITS-1:0] rdData,
  output logic                 fifoEmpty,
  output logic                 fifoOneLeft,
  output logic                 fifoFull,
  output logic                 frameErr,
  output logic                 overrunErr
);
  localparam int HB = DIV_W / 2;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DIV_W-1:0]     divisor;
  logic [DIV_W-1:0]     divCnt;
  logic [1:0]           syncQ;
  logic [DATA_BITS-1:0] shiftReg;
  logic [DATA_BITS-1:0] mem [DEPTH];
  logic [AW-1:0]        wrPtr;
  logic [AW-1:0]        rdPtr;
  logic [CW-1:0]        count;
  logic                 doPush;
  logic                 doPop;

  function automatic logic [AW-1:0] bumpPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // divisor and tick generator
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divisor <= DIV_W'(DIV_INIT);
      divCnt  <= '0;
    end else begin
      if (divWrLo) divisor[HB-1:0]    <= divWrData;
      if (divWrHi) divisor[DIV_W-1:HB] <= divWrData;
      if (divWrLo || divWrHi || tick) divCnt <= '0;
      else divCnt <= divCnt + DIV_W'(1);
    end
  end
  assign tick = (divCnt == divisor);

  // line synchroniser, idle high
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= 2'b11;
    else syncQ <= {syncQ[0], serialIn};
  end
  assign rxBit = syncQ[1];

  // data bits arrive least significant first
  always_ff @(posedge clk) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {rxBit, shiftReg[DATA_BITS-1:1]};
  end

  // receive queue
  assign fifoEmpty   = (count == '0);
  assign fifoFull    = (count == CW'(DEPTH));
  assign fifoOneLeft = (count == CW'(DEPTH - 1));
  assign doPush      = strobe.pushEn && !fifoFull;
  assign doPop       = popEn && !fifoEmpty;
  assign rdData      = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= shiftReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bumpPtr(wrPtr);
      if (doPop)  rdPtr <= bumpPtr(rdPtr);
      unique case ({doPush, doPop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // sticky errors: a new event beats a clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      if (strobe.stopLow) frameErr <= 1'b1;
      else if (clrFrameErr) frameErr <= 1'b0;
      if (strobe.pushEn && fifoFull) overrunErr <= 1'b1;
      else if (clrOverrunErr) overrunErr <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx4x.sv
module uart_rx4x
  import uart_rx4x_pkg::*;
#(
  parameter int          DIV_W     = 16,
  parameter logic [15:0] DIV_INIT  = 16'd3,
  parameter int          DATA_BITS = 8,
  parameter int          DEPTH     = 4,
  parameter int          TICKS     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 divWrLo,
  input  logic                 divWrHi,
  input  logic [DIV_W/2-1:0]   divWrData,
  input  logic                 serialIn,
  input  logic                 popEn,
  input  logic                 clrFrameErr,
  input  logic                 clrOverrunErr,
  output logic [DATA_BITS-1:0] rdData,
  output logic                 fifoEmpty,
  output logic                 fifoOneLeft,
  output logic                 fifoFull,
  output logic                 frameErr,
  output logic                 overrunErr
);
  rxStrobe_t strobe;
  logic      tick;
  logic      rxBit;

  uart_rx4x_ctrl #(
    .TICKS_PER_BIT(TICKS),
    .DATA_BITS    (DATA_BITS)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .tick  (tick),
    .rxBit (rxBit),
    .strobe(strobe)
  );

  uart_rx4x_dp #(
    .DIV_W    (DIV_W),
    .DIV_INIT (DIV_INIT),
    .DATA_BITS(DATA_BITS),
    .DEPTH    (DEPTH)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .divWrLo      (divWrLo),
    .divWrHi      (divWrHi),
    .divWrData    (divWrData),
    .serialIn     (serialIn),
    .strobe       (strobe),
    .popEn        (popEn),
    .clrFrameErr  (clrFrameErr),
    .clrOverrunErr(clrOverrunErr),
    .tick         (tick),
    .rxBit        (rxBit),
    .rdData       (rdData),
    .fifoEmpty    (fifoEmpty),
    .fifoOneLeft  (fifoOneLeft),
    .fifoFull     (fifoFull),
    .frameErr     (frameErr),
    .overrunErr   (overrunErr)
  );
endmodule

// File: rtl/uart_rx4x_chk.sv
module uart_rx4x_chk (
  input logic clk,
  input logic rstN,
  input logic fifoEmpty,
  input logic fifoOneLeft,
  input logic fifoFull,
  input logic frameErr,
  input logic overrunErr,
  input logic clrFrameErr,
  input logic clrOverrunErr
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fifoEmpty, fifoOneLeft, fifoFull})); // R4

  AST_OVERRUN_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunErr) |-> $past(fifoFull)); // R5

  AST_FRAME_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(frameErr) && !$past(fifoFull)) |-> !fifoEmpty); // R6

  AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && !clrFrameErr) |=> frameErr); // R7

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrunErr && !clrOverrunErr) |=> overrunErr); // R7
endmodule

bind uart_rx4x uart_rx4x_chk chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .fifoEmpty    (fifoEmpty),
  .fifoOneLeft  (fifoOneLeft),
  .fifoFull     (fifoFull),
  .frameErr     (frameErr),
  .overrunErr   (overrunErr),
  .clrFrameErr  (clrFrameErr),
  .clrOverrunErr(clrOverrunErr)
);

// File: tb/uart_rx4x_tb_top.sv
`timescale 1ns/1ps
module uart_rx4x_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       divWrLo = 1'b0;
  logic       divWrHi = 1'b0;
  logic [7:0] divWrData = '0;
  logic       serialIn = 1'b1;
  logic       popEn = 1'b0;
  logic       clrFrameErr = 1'b0;
  logic       clrOverrunErr = 1'b0;
  logic [7:0] rdData;
  logic       fifoEmpty, fifoOneLeft, fifoFull, frameErr, overrunErr;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int curDiv = 3;
  logic [7:0] mq[$];
  logic expFrame = 1'b0;
  logic expOvr = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx4x dut_i (
    .clk(clk), .rstN(rstN), .divWrLo(divWrLo), .divWrHi(divWrHi),
    .divWrData(divWrData), .serialIn(serialIn), .popEn(popEn),
    .clrFrameErr(clrFrameErr), .clrOverrunErr(clrOverrunErr),
    .rdData(rdData), .fifoEmpty(fifoEmpty), .fifoOneLeft(fifoOneLeft),
    .fifoFull(fifoFull), .frameErr(frameErr), .overrunErr(overrunErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic setDiv(input int d);
    @(negedge clk); divWrData = d[7:0]; divWrLo = 1'b1;
    @(negedge clk); divWrLo = 1'b0; divWrData = d[15:8]; divWrHi = 1'b1;
    @(negedge clk); divWrHi = 1'b0;
    curDiv = d;
  endtask

  task automatic holdBit(input logic v);
    serialIn = v;
    repeat (4 * (curDiv + 1)) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic stopVal);
    @(negedge clk);
    holdBit(1'b0);
    for (int i = 0; i < 8; i++) holdBit(b[i]);
    holdBit(stopVal);
    holdBit(1'b1);
    if (mq.size() == 4) expOvr = 1'b1;
    else mq.push_back(b);
    if (!stopVal) expFrame = 1'b1;
  endtask

  task automatic checkFlags(input string req);
    int n = mq.size();
    chk({req, " empty"}, {31'd0, fifoEmpty}, {31'd0, n == 0});
    chk({req, " oneLeft"}, {31'd0, fifoOneLeft}, {31'd0, n == 3});
    chk({req, " full"}, {31'd0, fifoFull}, {31'd0, n == 4});
  endtask

  task automatic popCheck(input string req);
    logic [7:0] e;
    e = mq.pop_front();
    chk(req, {24'd0, rdData}, {24'd0, e});
    @(negedge clk); popEn = 1'b1;
    @(negedge clk); popEn = 1'b0;
  endtask

  task automatic drain(input string req);
    while (mq.size() > 0) popCheck(req);
    chk({req, " drained"}, {31'd0, fifoEmpty}, 32'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 empty", {31'd0, fifoEmpty}, 32'd1);
    chk("R8 full", {31'd0, fifoFull}, 32'd0);
    chk("R8 oneLeft", {31'd0, fifoOneLeft}, 32'd0);
    chk("R8 frameErr", {31'd0, frameErr}, 32'd0);
    chk("R8 overrunErr", {31'd0, overrunErr}, 32'd0);
    // R8 reset divisor is 3: receive without writing it
    sendFrame(8'hA5, 1'b1);
    checkFlags("R8 after first byte");
    popCheck("R2 first byte at reset divisor");

    // R1 R2 R4 random divisors, bytes and fill depth
    for (int it = 0; it < 16; it++) begin
      int dsel = $urandom % 4;
      int n = 1 + ($urandom % 4);
      setDiv(dsel == 0 ? 0 : (dsel == 1 ? 1 : (dsel == 2 ? 3 : 6)));
      for (int k = 0; k < n; k++) begin
        sendFrame(8'($urandom), 1'b1);
        checkFlags("R4 random fill");
      end
      drain("R2 random byte");
    end

    // R1 high divisor byte in use (257 clocks per tick)
    setDiv(16'h0100);
    sendFrame(8'h3D, 1'b1);
    popCheck("R1 high divisor byte");
    setDiv(3);

    // R5 overrun keeps four bytes, discards fifth
    sendFrame(8'h11, 1'b1); sendFrame(8'h22, 1'b1);
    sendFrame(8'h33, 1'b1);
    checkFlags("R4 three stored");
    sendFrame(8'h44, 1'b1);
    checkFlags("R4 four stored");
    chk("R5 no overrun yet", {31'd0, overrunErr}, 32'd0);
    sendFrame(8'h55, 1'b1);
    chk("R5 overrun set", {31'd0, overrunErr}, {31'd0, expOvr});
    checkFlags("R5 still full");
    chk("R7 frame untouched", {31'd0, frameErr}, 32'd0);
    // R7 clear overrun leaves data
    @(negedge clk); clrOverrunErr = 1'b1;
    @(negedge clk); clrOverrunErr = 1'b0; expOvr = 1'b0;
    chk("R7 overrun cleared", {31'd0, overrunErr}, 32'd0);
    checkFlags("R7 clear keeps data");
    drain("R5 kept bytes");

    // R6 frame error stores byte
    sendFrame(8'h3C, 1'b0);
    chk("R6 frame set", {31'd0, frameErr}, {31'd0, expFrame});
    checkFlags("R6 byte stored");
    sendFrame(8'h5A, 1'b1);
    chk("R7 frame sticky", {31'd0, frameErr}, 32'd1);
    drain("R6 bytes");
    @(negedge clk); clrFrameErr = 1'b1;
    @(negedge clk); clrFrameErr = 1'b0; expFrame = 1'b0;
    chk("R7 frame cleared", {31'd0, frameErr}, 32'd0);

    // R3 short glitch is rejected
    @(negedge clk); serialIn = 1'b0;
    repeat (3) @(negedge clk);
    serialIn = 1'b1;
    repeat (200) @(negedge clk);
    chk("R3 glitch ignored", {31'd0, fifoEmpty}, 32'd1);
    sendFrame(8'h81, 1'b1);
    popCheck("R3 byte after glitch");

    // R4 pop while empty changes nothing
    @(negedge clk); popEn = 1'b1;
    @(negedge clk); popEn = 1'b0;
    checkFlags("R4 empty pop");
    sendFrame(8'hC3, 1'b1);
    sendFrame(8'h0F, 1'b1);
    checkFlags("R4 after empty pop");
    drain("R4 order after empty pop");
    chk("R5 no spurious overrun", {31'd0, overrunErr}, 32'd0);

    finish();
  end
endmodule